// File: doc/BRIEF.md
# Multi-Mode 16-bit Waveform Timer

A 16-bit counter whose behaviour is chosen by a 4-bit waveform mode. The mode selects one of five counting styles: plain up-count, clear-on-compare, single-slope PWM, dual-slope PWM, or hold. It also selects where the wrap point (TOP) comes from, when written compare values become active, and which counter event raises the overflow flag. Two compare channels, A and B, are provided. Channel A can also serve as TOP. Channel B drives the single PWM output.

Each count step is qualified by a clock enable. The enable comes either from an upstream prescaler pulse or from rising edges of an external count pin, which is synchronised inside the block. The pin is sampled whatever its direction is set to elsewhere on the chip. Two low mode bits come from one control register field and two high bits from another. A capture register can be written as a TOP source. Three sticky flags report overflow and the two compare matches, and each can be cleared with a write-one pulse.

Top module: `wavetimer16`

## Requirements
- R1: The mode is {ctlb_mode[1:0], ctla_mode[1:0]}: ctla_mode gives mode bits 1:0 and ctlb_mode gives bits 3:2.
- R2: Mode 0 counts up by one per count step, wraps from 0xFFFF to 0, and sets ovf_flag on the step taken at 0xFFFF. Compare writes take effect on the next cycle.
- R3: Modes 4 and 12 return the counter to 0 on the step taken at TOP, where TOP is compare A for mode 4 and the capture register for mode 12. Compare writes apply at once, ovf_flag sets only at 0xFFFF, and the PWM pin holds.
- R4: Single-slope PWM (modes 5-7, 14, 15) counts 0..TOP. On the step at TOP it sets ovf_flag and sets the raw pin to 1. On a step where the count equals active compare B, the raw pin clears to 0, and the TOP event wins a tie.
- R5: Dual-slope PWM (modes 1-3, 8-11) counts up to TOP and then down to 0. ovf_flag sets on the step taken at 0 while counting down. A B match while counting up clears the raw pin, and a B match while counting down sets it.
- R6: In PWM modes a compare write lands in a buffer. The buffer becomes active on the step at TOP for modes 1-3, 10 and 11, and on the step at 0 for modes 5-9, 14 and 15.
- R7: The fixed TOP is 0x00FF, 0x01FF or 0x03FF for mode low bits 01, 10 and 11 in modes 1-3 and 5-7. Modes 8, 10, 12 and 14 take TOP from the capture register. Modes 9, 11, 15 and 4 take TOP from compare A.
- R8: In mode 13 the counter holds and no flag is set.
- R9: With ext_sel high, each rising edge of ext_pin gives exactly one count step and tick_en is ignored. With ext_sel low, each cycle with tick_en high is one step.
- R10: cmp_a_flag and cmp_b_flag set on a step where the count equals the active compare value. flag_clr bit 0 clears ovf_flag, bit 1 clears cmp_a_flag and bit 2 clears cmp_b_flag.
- R11: Reset gives count 0, all flags 0, raw pin 0, compare and capture values 0, and direction up.
- R12: pwm_out is the raw pin inverted when pwm_inv is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| ext_sel | input | 1 | Count from external pin edges |
| ext_pin | input | 1 | External count pin |
| ctla_mode | input | 2 | Mode bits 1:0 |
| ctlb_mode | input | 2 | Mode bits 3:2 |
| pwm_inv | input | 1 | Invert PWM output |
| wr_data | input | 16 | Write data for compare/capture |
| cmp_a_wr | input | 1 | Write compare A |
| cmp_b_wr | input | 1 | Write compare B |
| cap_wr | input | 1 | Write capture register |
| flag_clr | input | 3 | Write-one-to-clear flags |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Overflow flag |
| cmp_a_flag | output | 1 | Compare A match flag |
| cmp_b_flag | output | 1 | Compare B match flag |
| pwm_out | output | 1 | PWM output pin |

## Verification
The hardest case to reach is a compare value that is buffered rather than applied at once. It only shows at the pin when the new value is written in mid-period, while the pin is high and the count is below both the old and the new threshold. The stimulus uses a run-until-count helper to stop the counter at exact values in single-slope mode. There it writes a smaller compare B and checks that the pin stays high past the new threshold in the current period, then falls at that threshold in the next period. The 0xFFFF wrap in mode 0 is reached by stepping through the full 16-bit range.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [2:0] {K_NORMAL, K_CTC, K_FAST, K_DUAL, K_HOLD} kind_e;
  typedef enum logic [1:0] {TS_FULL, TS_FIX, TS_CMPA, TS_CAP} tsrc_e;
  typedef enum logic [1:0] {UP_IMM, UP_TOP, UP_BOT} upd_e;
  typedef enum logic [1:0] {OV_MAX, OV_TOP, OV_BOT} ovp_e;

  typedef struct packed {
    kind_e      kind;
    tsrc_e      tsrc;
    logic [1:0] res;
    upd_e       upd;
    ovp_e       ovp;
  } mode_cfg_t;
endpackage

// File: rtl/wt_mode_dec.sv
module wt_mode_dec
  import wt_pkg::*;
(
  input  logic [3:0] mode,
  output mode_cfg_t  cfg
);
  always_comb begin
    cfg = '{K_HOLD, TS_FULL, 2'd0, UP_IMM, OV_MAX};
    unique case (mode)
      4'd0:              cfg = '{K_NORMAL, TS_FULL, 2'd0, UP_IMM, OV_MAX};
      4'd1, 4'd2, 4'd3:  cfg = '{K_DUAL, TS_FIX, 2'(mode[1:0] - 2'd1), UP_TOP, OV_BOT};
      4'd4:              cfg = '{K_CTC, TS_CMPA, 2'd0, UP_IMM, OV_MAX};
      4'd5, 4'd6, 4'd7:  cfg = '{K_FAST, TS_FIX, 2'(mode[1:0] - 2'd1), UP_BOT, OV_TOP};
      4'd8:              cfg = '{K_DUAL, TS_CAP, 2'd0, UP_BOT, OV_BOT};
      4'd9:              cfg = '{K_DUAL, TS_CMPA, 2'd0, UP_BOT, OV_BOT};
      4'd10:             cfg = '{K_DUAL, TS_CAP, 2'd0, UP_TOP, OV_BOT};
      4'd11:             cfg = '{K_DUAL, TS_CMPA, 2'd0, UP_TOP, OV_BOT};
      4'd12:             cfg = '{K_CTC, TS_CAP, 2'd0, UP_IMM, OV_MAX};
      4'd14:             cfg = '{K_FAST, TS_CAP, 2'd0, UP_BOT, OV_TOP};
      4'd15:             cfg = '{K_FAST, TS_CMPA, 2'd0, UP_BOT, OV_TOP};
      default:           cfg = '{K_HOLD, TS_FULL, 2'd0, UP_IMM, OV_MAX};
    endcase
  end
endmodule

// File: rtl/wt_pin_sync.sv
module wt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  always_comb sync_d = {sync_q[STAGES-2:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/wt_cmp_slot.sv
module wt_cmp_slot #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          imm,
  input  logic          load,
  output logic [CW-1:0] act_q
);
  logic [CW-1:0] buf_q, buf_d, act_d;

  always_comb begin
    buf_d = wr ? wdata : buf_q;
    act_d = act_q;
    if (imm) begin
      if (wr) act_d = wdata;
    end else if (load) begin
      act_d = buf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/wavetimer16.sv
module wavetimer16
  import wt_pkg::*;
#(
  parameter int CW       = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          ext_sel,
  input  logic          ext_pin,
  input  logic [1:0]    ctla_mode,
  input  logic [1:0]    ctlb_mode,
  input  logic          pwm_inv,
  input  logic [CW-1:0] wr_data,
  input  logic          cmp_a_wr,
  input  logic          cmp_b_wr,
  input  logic          cap_wr,
  input  logic [2:0]    flag_clr,
  output logic [CW-1:0] count,
  output logic          ovf_flag,
  output logic          cmp_a_flag,
  output logic          cmp_b_flag,
  output logic          pwm_out
);
  localparam int NCMP = 2;
  localparam logic [CW-1:0] ONES  = '1;
  localparam logic [CW-1:0] FIX8  = ONES >> (CW - 8);
  localparam logic [CW-1:0] FIX9  = ONES >> (CW - 9);
  localparam logic [CW-1:0] FIX10 = ONES >> (CW - 10);

  logic [3:0]    mode;
  mode_cfg_t     cfg;
  logic          ext_rise, cnt_en;
  logic [CW-1:0] cnt_q, cnt_d, cap_q, cap_d, top_val, fix_top;
  logic          up_q, up_d, pin_q, pin_d;
  logic [2:0]    flags_q, flags_d, flag_set;
  logic          at_top, at_zero, at_max, top_evt, bot_evt, load_evt, live;
  logic [NCMP-1:0] slot_wr, slot_hit;
  logic [CW-1:0] act [NCMP];

  assign mode = {ctlb_mode, ctla_mode};

  wt_mode_dec u_dec (.mode(mode), .cfg(cfg));

  wt_pin_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(ext_rise)
  );

  assign cnt_en  = ext_sel ? ext_rise : tick_en;
  assign slot_wr = {cmp_b_wr, cmp_a_wr};

  generate
    for (genvar gi = 0; gi < NCMP; gi++) begin : g_slot
      wt_cmp_slot #(.CW(CW)) u_slot (
        .clk(clk), .rst_n(rst_n), .wr(slot_wr[gi]), .wdata(wr_data),
        .imm(cfg.upd == UP_IMM), .load(load_evt), .act_q(act[gi])
      );
      assign slot_hit[gi] = (cnt_q == act[gi]);
    end
  endgenerate

  always_comb begin
    unique case (cfg.res)
      2'd0:    fix_top = FIX8;
      2'd1:    fix_top = FIX9;
      default: fix_top = FIX10;
    endcase
    unique case (cfg.tsrc)
      TS_FIX:  top_val = fix_top;
      TS_CMPA: top_val = act[0];
      TS_CAP:  top_val = cap_q;
      default: top_val = ONES;
    endcase
  end

  assign live     = cnt_en && (cfg.kind != K_HOLD);
  assign at_top   = (cnt_q == top_val);
  assign at_zero  = (cnt_q == '0);
  assign at_max   = (cnt_q == ONES);
  assign top_evt  = at_top  && ((cfg.kind != K_DUAL) || up_q);
  assign bot_evt  = at_zero && ((cfg.kind != K_DUAL) || !up_q);
  assign load_evt = live && (((cfg.upd == UP_TOP) && top_evt) ||
                             ((cfg.upd == UP_BOT) && bot_evt));

  // counter and direction
  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (cnt_en) begin
      unique case (cfg.kind)
        K_NORMAL: begin cnt_d = cnt_q + CW'(1); up_d = 1'b1; end
        K_CTC, K_FAST: begin
          cnt_d = at_top ? '0 : cnt_q + CW'(1);
          up_d  = 1'b1;
        end
        K_DUAL: begin
          if (up_q) begin
            if (cnt_q >= top_val) begin
              up_d  = 1'b0;
              cnt_d = at_zero ? '0 : cnt_q - CW'(1);
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end else if (at_zero) begin
            up_d  = 1'b1;
            cnt_d = (top_val == '0) ? '0 : CW'(1);
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // flags and output pin
  always_comb begin
    flag_set    = '0;
    flag_set[1] = live && slot_hit[0];
    flag_set[2] = live && slot_hit[1];
    unique case (cfg.ovp)
      OV_TOP:  flag_set[0] = live && top_evt;
      OV_BOT:  flag_set[0] = live && bot_evt;
      default: flag_set[0] = live && at_max;
    endcase
    flags_d = (flags_q & ~flag_clr) | flag_set;

    pin_d = pin_q;
    if (live) begin
      if (cfg.kind == K_FAST) begin
        if (top_evt)          pin_d = 1'b1;
        else if (slot_hit[1]) pin_d = 1'b0;
      end else if (cfg.kind == K_DUAL) begin
        if (slot_hit[1])      pin_d = !up_q;
      end
    end
    cap_d = cap_wr ? wr_data : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      up_q    <= 1'b1;
      pin_q   <= 1'b0;
      flags_q <= '0;
      cap_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      up_q    <= up_d;
      pin_q   <= pin_d;
      flags_q <= flags_d;
      cap_q   <= cap_d;
    end
  end

  assign count      = cnt_q;
  assign ovf_flag   = flags_q[0];
  assign cmp_a_flag = flags_q[1];
  assign cmp_b_flag = flags_q[2];
  assign pwm_out    = pin_q ^ pwm_inv;
endmodule

// File: rtl/wt_chk.sv
module wt_chk
  import wt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input mode_cfg_t     cfg,
  input logic          cnt_en,
  input logic [CW-1:0] count,
  input logic [2:0]    flags,
  input logic [CW-1:0] top_val,
  input logic          up_q,
  input logic [2:0]    flag_clr
);
  // R2
  normal_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0 && cnt_en && count == {CW{1'b1}}) |=> (count == '0 && flags[0]));

  // R3
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.kind == K_CTC && cnt_en && count == top_val) |=> (count == '0));

  // R4
  fast_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.kind == K_FAST && cnt_en && count == top_val) |=> (count == '0 && flags[0]));

  // R5
  dual_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.kind == K_DUAL && cnt_en && count == '0 && !up_q) |=> (up_q && flags[0]));

  // R8
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd13 && flag_clr == 3'b000) |=> ($stable(count) && $stable(flags)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en) |=> $stable(count));
endmodule

bind wavetimer16 wt_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .cfg(cfg), .cnt_en(cnt_en),
  .count(cnt_q), .flags(flags_q), .top_val(top_val), .up_q(up_q),
  .flag_clr(flag_clr)
);

// File: tb/wavetimer16_tb_top.sv
module wavetimer16_tb_top;
  logic        clk, rst_n, tick_en, ext_sel, ext_pin, pwm_inv;
  logic [1:0]  ctla_mode, ctlb_mode;
  logic [15:0] wr_data;
  logic        cmp_a_wr, cmp_b_wr, cap_wr;
  logic [2:0]  flag_clr;
  logic [15:0] count;
  logic        ovf_flag, cmp_a_flag, cmp_b_flag, pwm_out;
  int          n_chk = 0;
  int          n_fail = 0;

  wavetimer16 dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_sel(ext_sel),
    .ext_pin(ext_pin), .ctla_mode(ctla_mode), .ctlb_mode(ctlb_mode),
    .pwm_inv(pwm_inv), .wr_data(wr_data), .cmp_a_wr(cmp_a_wr),
    .cmp_b_wr(cmp_b_wr), .cap_wr(cap_wr), .flag_clr(flag_clr),
    .count(count), .ovf_flag(ovf_flag), .cmp_a_flag(cmp_a_flag),
    .cmp_b_flag(cmp_b_flag), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick_en = 1'b0; ext_sel = 1'b0; ext_pin = 1'b0;
    pwm_inv = 1'b0; ctla_mode = 2'b00; ctlb_mode = 2'b00; wr_data = '0;
    cmp_a_wr = 1'b0; cmp_b_wr = 1'b0; cap_wr = 1'b0; flag_clr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    ctla_mode = m[1:0];
    ctlb_mode = m[3:2];
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic run_to(input logic [15:0] v);
    while (count !== v) run(1);
  endtask

  // which: 0 = compare A, 1 = compare B, 2 = capture
  task automatic wr_reg(input int which, input logic [15:0] v);
    wr_data  = v;
    cmp_a_wr = (which == 0);
    cmp_b_wr = (which == 1);
    cap_wr   = (which == 2);
    @(negedge clk);
    cmp_a_wr = 1'b0; cmp_b_wr = 1'b0; cap_wr = 1'b0;
  endtask

  task automatic clear_flags(input logic [2:0] m);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic t_reset();
    pwm_inv = 1'b1;
    do_reset();
    check("R11 count", count, 0);
    check("R11 flags", {ovf_flag, cmp_a_flag, cmp_b_flag}, 0);
    pwm_inv = 1'b1;
    #1 check("R12 inverted pin at reset", pwm_out, 1);
    pwm_inv = 1'b0;
    #1 check("R11 pin low", pwm_out, 0);
  endtask

  task automatic t_normal();
    do_reset();
    set_mode(4'd0);
    wr_reg(0, 16'd5);
    wr_reg(1, 16'd5);
    run(5);
    check("R2 count after 5", count, 5);
    check("R10 no match yet", cmp_a_flag, 0);
    run(1);
    check("R10 match flags", {cmp_a_flag, cmp_b_flag}, 2'b11);
    clear_flags(3'b010);
    check("R10 clear A only", {cmp_a_flag, cmp_b_flag}, 2'b01);
    run(65529);
    check("R2 at max", count, 16'hFFFF);
    check("R2 no ovf before wrap", ovf_flag, 0);
    run(1);
    check("R2 wrap", count, 0);
    check("R2 ovf at max", ovf_flag, 1);
  endtask

  task automatic t_ctc();
    do_reset();
    set_mode(4'd4);
    wr_reg(0, 16'd9);
    run(9);
    check("R3 count to top", count, 9);
    run(1);
    check("R3 clear at compare A", count, 0);
    check("R3 no ovf", ovf_flag, 0);
    check("R3 pin holds", pwm_out, 0);
    do_reset();
    set_mode(4'd12);
    wr_reg(2, 16'd3);
    run_to(16'd3);
    run(1);
    check("R1 R3 mode 12 clear at capture", count, 0);
  endtask

  task automatic t_fast();
    do_reset();
    set_mode(4'd5);
    wr_reg(1, 16'h0010);
    run_to(16'h00FF);
    check("R4 no ovf before top", ovf_flag, 0);
    run(1);
    check("R4 wrap at top", count, 0);
    check("R4 ovf at top", ovf_flag, 1);
    check("R4 pin set at top", pwm_out, 1);
    run(1);
    wr_reg(1, 16'h0008);
    run_to(16'h0009);
    check("R6 buffered compare not yet active", pwm_out, 1);
    run_to(16'h0011);
    check("R4 pin cleared at match", pwm_out, 0);
    run_to(16'h0000);
    check("R4 pin set again", pwm_out, 1);
    run(1);
    run_to(16'h0009);
    check("R6 new compare active after bottom", pwm_out, 0);
  endtask

  task automatic t_tops();
    do_reset();
    set_mode(4'd6);
    run_to(16'h01FF);
    run(1);
    check("R7 9-bit top", {count, 15'b0, ovf_flag}, {16'h0000, 15'b0, 1'b1});
    do_reset();
    set_mode(4'd7);
    run_to(16'h03FF);
    check("R7 10-bit no early ovf", ovf_flag, 0);
    run(1);
    check("R7 10-bit top", count, 0);
    do_reset();
    set_mode(4'd15);
    wr_reg(0, 16'h0020);
    run(1);
    clear_flags(3'b111);
    run_to(16'h0020);
    check("R7 compare A top no early ovf", ovf_flag, 0);
    run(1);
    check("R7 compare A top wrap", {count, 15'b0, ovf_flag}, {16'h0000, 15'b0, 1'b1});
  endtask

  task automatic t_dual();
    do_reset();
    set_mode(4'd1);
    wr_reg(1, 16'h0040);
    run_to(16'h00FF);
    check("R5 pin low on way up", pwm_out, 0);
    run(1);
    check("R5 turn down at top", count, 16'h00FE);
    check("R5 no ovf at top", ovf_flag, 0);
    run_to(16'h003F);
    check("R5 pin set on down match", pwm_out, 1);
    run_to(16'h0000);
    check("R5 no ovf before bottom", ovf_flag, 0);
    run(1);
    check("R5 turn up at bottom", count, 1);
    check("R5 ovf at bottom", ovf_flag, 1);
    run_to(16'h0041);
    check("R5 pin clear on up match", pwm_out, 0);
  endtask

  task automatic t_reserved();
    do_reset();
    set_mode(4'd0);
    wr_reg(0, 16'd5);
    run(5);
    clear_flags(3'b111);
    set_mode(4'd13);
    run(10);
    check("R8 counter holds", count, 5);
    check("R8 no flags", {ovf_flag, cmp_a_flag, cmp_b_flag}, 0);
  endtask

  task automatic t_ext();
    do_reset();
    set_mode(4'd0);
    ext_sel = 1'b1;
    tick_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      ext_pin = 1'b1;
      repeat (3) @(negedge clk);
      ext_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R9 one step per pin edge", count, 7);
    tick_en = 1'b0;
    ext_sel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_normal();
    t_ctc();
    t_fast();
    t_tops();
    t_dual();
    t_reserved();
    t_ext();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule